// File: doc/BRIEF.md
# I2C Register Access Sequencer with Retry

This block turns a single register request into the ordered list of bus primitives that a bit-level I2C engine executes. A request carries a write/read flag, an 8-bit target address byte, a register index and, for writes, a data byte. The sequencer presents one primitive at a time to the engine, waits for the engine to report completion, gathers the acknowledge results, and repeats the whole transaction when any acknowledge is missing. It gives up after a fixed number of extra attempts.

A write addresses the target, sends the register index and sends the data byte, checking the acknowledge after each of the three. A read addresses the target, sends the register index, pauses for one low time, issues a repeated START, addresses the target again in read mode, receives one byte, answers it with a NACK, and closes with STOP. The result (error code and, for reads, the received byte) is registered and stays on the outputs until the next request is accepted. The pause lengths and the retry limit are parameters.

Top module: `i2c_reg_seq`

## Requirements
- R1: After reset, busy, done and cmd_valid are low and err_code and rd_data are zero.
- R2: A write presents, in order, the operation codes START (0), SEND (2) with the address byte with bit 0 cleared, GET_ACK (3), SEND with the register index, GET_ACK, SEND with the write data, GET_ACK, and STOP (1).
- R3: In a write, a missing acknowledge after the address sets err_code bit 0, after the register index bit 1, and after the data byte bit 2; several bits may be set at once.
- R4: A read presents START, SEND address with bit 0 cleared, GET_ACK, SEND register index, GET_ACK, START, SEND address with bit 0 set, GET_ACK, RECV (4), NACK (5) and STOP; rd_data takes the byte returned with the RECV completion.
- R5: In a read, any missing acknowledge makes err_code equal to 1.
- R6: An attempt that ends with a nonzero error is repeated from its first START, up to MAX_RETRY extra attempts (four attempts in total by default); err_code and rd_data report the last attempt only.
- R7: done rises in the cycle right after the final STOP completes for a read, and LOW_CYC cycles after that STOP completion for a write.
- R8: In a read, the repeated START is presented LOW_CYC+1 cycles after the cycle in which the second acknowledge check completes, with no primitive presented in between.
- R9: busy goes high the cycle after a request is accepted and stays high until done; done lasts exactly one cycle and busy is low while done is high; cmd_valid is only high while busy.
- R10: A request is accepted only when busy and done are both low; requests raised at other times have no effect on the primitives or the result.
- R11: err_code and rd_data keep their value from the done pulse until the next request is accepted.
- R12: Once cmd_valid is high, cmd_valid, cmd_op and cmd_byte hold steady until the engine reports completion with eng_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_read | input | 1 | 1 selects a read, 0 a write |
| req_addr | input | 8 | Target address byte (bit 0 replaced by the sequencer) |
| req_reg | input | 8 | Register index |
| req_wdata | input | 8 | Data byte for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte received by the last read |
| err_code | output | 3 | Acknowledge error code of the last attempt |
| cmd_valid | output | 1 | A primitive is presented to the engine |
| cmd_op | output | 3 | Primitive code: 0 START, 1 STOP, 2 SEND, 3 GET_ACK, 4 RECV, 5 NACK |
| cmd_byte | output | 8 | Byte to send with SEND |
| eng_done | input | 1 | Engine finished the presented primitive (one-cycle pulse) |
| eng_ack | input | 1 | With a GET_ACK completion: 1 when the target acknowledged |
| eng_rdata | input | 8 | With a RECV completion: the received byte |

## Verification
The assertions assume an engine that raises eng_done for exactly one cycle and only while cmd_valid is high, and that qualifies eng_ack and eng_rdata with that pulse. The bench's engine model obeys this: it latches each presented primitive, waits a fixed latency and then pulses eng_done once, never while idle. Requests are raised for single cycles, including deliberate ones during a running transaction, so the assumption that the request strobe is sampled only when idle is exercised rather than relied upon.

// File: rtl/seq_pkg.sv
package seq_pkg;

   // Primitive codes seen by the bit-level engine; WAIT never leaves the block.
   typedef enum logic [2:0] {
      OP_START  = 3'd0,
      OP_STOP   = 3'd1,
      OP_SEND   = 3'd2,
      OP_GETACK = 3'd3,
      OP_RECV   = 3'd4,
      OP_NACK   = 3'd5,
      OP_WAIT   = 3'd7
   } seq_op_e;

   typedef enum logic [1:0] {
      SEL_ADDR_W = 2'd0,
      SEL_REG    = 2'd1,
      SEL_DATA   = 2'd2,
      SEL_ADDR_R = 2'd3
   } byte_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_PAUSE = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_e;

   localparam int STEP_W    = 4;
   localparam logic [1:0] SLOT_NONE = 2'd3;

endpackage

// File: rtl/seq_step_rom.sv
module seq_step_rom
   import seq_pkg::*;
(
   input  logic              is_read,
   input  logic [STEP_W-1:0] step,
   output seq_op_e           op,
   output byte_sel_e         sel,
   output logic [1:0]        slot,
   output logic              last
);

   always_comb begin
      op   = OP_STOP;
      sel  = SEL_ADDR_W;
      slot = SLOT_NONE;
      last = 1'b0;
      if (!is_read) begin
         case (step)
            4'd0: op = OP_START;
            4'd1: begin op = OP_SEND;   sel = SEL_ADDR_W; end
            4'd2: begin op = OP_GETACK; slot = 2'd0;      end
            4'd3: begin op = OP_SEND;   sel = SEL_REG;    end
            4'd4: begin op = OP_GETACK; slot = 2'd1;      end
            4'd5: begin op = OP_SEND;   sel = SEL_DATA;   end
            4'd6: begin op = OP_GETACK; slot = 2'd2;      end
            default: begin op = OP_STOP; last = 1'b1;     end
         endcase
      end else begin
         case (step)
            4'd0:  op = OP_START;
            4'd1:  begin op = OP_SEND;   sel = SEL_ADDR_W; end
            4'd2:  begin op = OP_GETACK; slot = 2'd0;      end
            4'd3:  begin op = OP_SEND;   sel = SEL_REG;    end
            4'd4:  begin op = OP_GETACK; slot = 2'd1;      end
            4'd5:  op = OP_WAIT;
            4'd6:  op = OP_START;
            4'd7:  begin op = OP_SEND;   sel = SEL_ADDR_R; end
            4'd8:  begin op = OP_GETACK; slot = 2'd2;      end
            4'd9:  op = OP_RECV;
            4'd10: op = OP_NACK;
            default: begin op = OP_STOP; last = 1'b1;      end
         endcase
      end
   end

endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
   parameter int LOW_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expire
);

   if (LOW_CYC < 1) begin : g_bad_low
      $error("seq_wait_timer: LOW_CYC must be at least 1");
   end

   if (LOW_CYC == 1) begin : g_single
      logic run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) run_q <= 1'b0;
         else        run_q <= start;
      end
      assign expire = run_q;
   end else begin : g_count
      localparam int CW = $clog2(LOW_CYC);
      logic [CW-1:0] cnt_q;
      logic          run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= CW'(LOW_CYC - 1);
         end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
         end
      end
      assign expire = run_q && (cnt_q == '0);
   end

endmodule

// File: rtl/seq_retry_track.sv
module seq_retry_track #(
   parameter int MAX_RETRY = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear_all,
   input  logic       restart,
   input  logic       nack_set,
   input  logic [1:0] slot,
   input  logic       is_read,
   output logic [2:0] err,
   output logic       can_retry
);

   if (MAX_RETRY < 0 || MAX_RETRY > 255) begin : g_bad_retry
      $error("seq_retry_track: MAX_RETRY out of range");
   end

   localparam int TW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

   logic [TW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err    <= '0;
         left_q <= '0;
      end else if (clear_all) begin
         err    <= '0;
         left_q <= TW'(MAX_RETRY);
      end else if (restart) begin
         err    <= '0;
         left_q <= left_q - 1'b1;
      end else if (nack_set) begin
         err <= err | (is_read ? 3'b001 : (3'b001 << slot));
      end
   end

   assign can_retry = (left_q != '0);

endmodule

// File: rtl/i2c_reg_seq.sv
module i2c_reg_seq
   import seq_pkg::*;
#(
   parameter int LOW_CYC   = 4,
   parameter int MAX_RETRY = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_read,
   input  logic [7:0] req_addr,
   input  logic [7:0] req_reg,
   input  logic [7:0] req_wdata,
   output logic       busy,
   output logic       done,
   output logic [7:0] rd_data,
   output logic [2:0] err_code,
   output logic       cmd_valid,
   output logic [2:0] cmd_op,
   output logic [7:0] cmd_byte,
   input  logic       eng_done,
   input  logic       eng_ack,
   input  logic [7:0] eng_rdata
);

   seq_state_e        st_q;
   logic [STEP_W-1:0] step_q;
   logic              rd_q, final_q;
   logic [7:0]        addr_q, reg_q, wdata_q;

   seq_op_e    op;
   byte_sel_e  sel;
   logic [1:0] slot;
   logic       last, expire, can_retry;
   logic       accept, in_cmd, fin, nack_set, try_end, restart, t_start;

   seq_step_rom u_rom (
      .is_read (rd_q),
      .step    (step_q),
      .op      (op),
      .sel     (sel),
      .slot    (slot),
      .last    (last)
   );

   assign accept   = (st_q == ST_IDLE) && req_valid;
   assign in_cmd   = (st_q == ST_RUN) && (op != OP_WAIT);
   assign fin      = in_cmd && eng_done;
   assign nack_set = fin && (op == OP_GETACK) && !eng_ack;
   assign try_end  = fin && last;
   assign restart  = try_end && (err_code != 3'b000) && can_retry;
   assign t_start  = ((st_q == ST_RUN) && (op == OP_WAIT)) ||
                     (try_end && !restart && !rd_q);

   seq_retry_track #(.MAX_RETRY(MAX_RETRY)) u_retry (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_all (accept),
      .restart   (restart),
      .nack_set  (nack_set),
      .slot      (slot),
      .is_read   (rd_q),
      .err       (err_code),
      .can_retry (can_retry)
   );

   seq_wait_timer #(.LOW_CYC(LOW_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (t_start),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         step_q  <= '0;
         rd_q    <= 1'b0;
         final_q <= 1'b0;
         addr_q  <= '0;
         reg_q   <= '0;
         wdata_q <= '0;
         rd_data <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (req_valid) begin
               st_q    <= ST_RUN;
               step_q  <= '0;
               rd_q    <= req_read;
               addr_q  <= req_addr;
               reg_q   <= req_reg;
               wdata_q <= req_wdata;
            end
            ST_RUN: begin
               if (op == OP_WAIT) begin
                  st_q    <= ST_PAUSE;
                  final_q <= 1'b0;
               end else if (fin) begin
                  if (op == OP_RECV) rd_data <= eng_rdata;
                  if (try_end) begin
                     if (restart) begin
                        step_q <= '0;
                     end else if (!rd_q) begin
                        st_q    <= ST_PAUSE;
                        final_q <= 1'b1;
                     end else begin
                        st_q <= ST_DONE;
                     end
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            ST_PAUSE: if (expire) begin
               if (final_q) begin
                  st_q <= ST_DONE;
               end else begin
                  st_q   <= ST_RUN;
                  step_q <= step_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_ADDR_W: cmd_byte = {addr_q[7:1], 1'b0};
         SEL_REG:    cmd_byte = reg_q;
         SEL_DATA:   cmd_byte = wdata_q;
         default:    cmd_byte = {addr_q[7:1], 1'b1};
      endcase
   end

   assign cmd_valid = in_cmd;
   assign cmd_op    = op;
   assign busy      = (st_q == ST_RUN) || (st_q == ST_PAUSE);
   assign done      = (st_q == ST_DONE);

   // R12: a presented primitive stays put until the engine completes it
   assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !eng_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

   // R9: done is a single-cycle pulse that follows a busy cycle
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));
   assert_cmd_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> busy);

   // R10: an idle request starts a transaction, a request while busy does not restart it
   assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done && req_valid) |=> (busy && cmd_valid && (cmd_op == 3'd0)));

   // R11: results stay fixed outside transactions
   assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(req_valid && !done)) |=> ($stable(err_code) && $stable(rd_data)));

endmodule

// File: tb/tb_i2c_reg_seq.sv
module tb_i2c_reg_seq;

   localparam int CLK_PERIOD = 10;
   localparam int LOW        = 3;

   typedef struct {
      logic [2:0] err;
      logic [7:0] rdv;
      int         att;
      bit         rd;
   } exp_t;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       req_valid = 1'b0, req_read = 1'b0;
   logic [7:0] req_addr = '0, req_reg = '0, req_wdata = '0;
   logic       busy, done, cmd_valid;
   logic [7:0] rd_data, cmd_byte;
   logic [2:0] err_code, cmd_op;
   logic       eng_done = 1'b0, eng_ack = 1'b1;
   logic [7:0] eng_rdata = '0;

   int total = 0, bad = 0, cyc = 0, done_cnt = 0;
   exp_t q[$];

   // transaction expected by the engine model
   bit         x_rd;
   logic [7:0] x_addr, x_reg, x_wd, x_rv;
   logic [2:0] x_mask;
   int         x_fails;
   int         tries_seen, ci, stop_cyc, ack1_cyc;
   bit         pend;
   int         pcnt, p_ci;
   logic [7:0] last_rd = '0;

   i2c_reg_seq #(.LOW_CYC(LOW), .MAX_RETRY(3)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
      .req_addr(req_addr), .req_reg(req_reg), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .err_code(err_code),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
      .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, expv);
      end
   endtask

   function automatic logic [2:0] exp_op(input int i);
      if (!x_rd) begin
         case (i)
            0: return 3'd0;  1, 3, 5: return 3'd2;  2, 4, 6: return 3'd3;
            default: return 3'd1;
         endcase
      end else begin
         case (i)
            0, 5: return 3'd0;  1, 3, 6: return 3'd2;  2, 4, 7: return 3'd3;
            8: return 3'd4;  9: return 3'd5;
            default: return 3'd1;
         endcase
      end
   endfunction

   function automatic logic [7:0] exp_byte(input int i);
      if (i == 1) return {x_addr[7:1], 1'b0};
      if (i == 3) return x_reg;
      if (i == 5 && !x_rd) return x_wd;
      return {x_addr[7:1], 1'b1};
   endfunction

   function automatic int ack_idx(input int i);
      if (i == 2) return 0;
      if (i == 4) return 1;
      return 2;
   endfunction

   // engine model: latch primitive, answer after two cycles
   always @(negedge clk) begin
      eng_done = 1'b0;
      if (pend) begin
         pcnt--;
         if (pcnt == 0) begin
            pend = 1'b0;
            eng_done = 1'b1;
            eng_ack = 1'b1;
            if (exp_op(p_ci) == 3'd3)
               eng_ack = !(tries_seen < x_fails && x_mask[ack_idx(p_ci)]);
            eng_rdata = x_rv ^ 8'(tries_seen);
            if (x_rd && p_ci == 4) ack1_cyc = cyc + 1;
            if (exp_op(p_ci) == 3'd1) begin
               stop_cyc = cyc + 1;
               tries_seen++;
               ci = 0;
            end else begin
               ci++;
            end
         end
      end else if (rst_n && cmd_valid) begin
         // R2 (write) / R4 (read): primitive order and bytes
         chk(cmd_op == exp_op(ci), x_rd ? "R4 op" : "R2 op", cmd_op, exp_op(ci));
         if (exp_op(ci) == 3'd2)
            chk(cmd_byte == exp_byte(ci), x_rd ? "R4 byte" : "R2 byte", cmd_byte, exp_byte(ci));
         if (x_rd && ci == 5)  // R8: pause before repeated START
            chk(cyc - ack1_cyc == LOW + 1, "R8 gap", cyc - ack1_cyc, LOW + 1);
         pend = 1'b1;
         pcnt = 2;
         p_ci = ci;
      end
   end

   // monitor: compare results on done against the scoreboard
   always @(negedge clk) begin
      if (rst_n && done) begin
         exp_t e;
         e = q.pop_front();
         chk(err_code == e.err, e.rd ? "R5/R6 err" : "R3/R6 err", err_code, e.err);
         chk(rd_data == e.rdv, "R4/R6 rd_data", rd_data, e.rdv);
         chk(tries_seen == e.att, "R6 attempts", tries_seen, e.att);
         chk(cyc - stop_cyc == (e.rd ? 0 : LOW), "R7 done timing", cyc - stop_cyc, e.rd ? 0 : LOW);
         chk(!busy, "R9 busy low at done", busy, 0);
         done_cnt++;
      end
   end

   task automatic run_txn(input bit rd, input logic [7:0] a, input logic [7:0] r, input logic [7:0] w,
                          input logic [2:0] mask, input int fails, input logic [7:0] rv, input bit poke);
      exp_t e;
      int start_cnt;
      logic [2:0] e0;
      logic [7:0] d0;
      x_rd = rd; x_addr = a; x_reg = r; x_wd = w; x_mask = mask; x_fails = fails; x_rv = rv;
      tries_seen = 0; ci = 0;
      e.rd  = rd;
      e.att = (mask == 3'b000) ? 1 : ((fails >= 4) ? 4 : fails + 1);
      e.err = (mask != 3'b000 && fails >= 4) ? (rd ? 3'b001 : mask) : 3'b000;
      e.rdv = rd ? (rv ^ 8'(e.att - 1)) : last_rd;
      last_rd = e.rdv;
      q.push_back(e);
      start_cnt = done_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_read = rd; req_addr = a; req_reg = r; req_wdata = w;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy, "R9 busy after accept", busy, 1);
      if (poke) begin  // R10: request while busy must be ignored
         repeat (5) @(negedge clk);
         req_valid = 1'b1; req_read = !rd; req_addr = 8'h5B; req_reg = 8'hE7; req_wdata = 8'h3C;
         @(negedge clk);
         req_valid = 1'b0;
         chk(busy, "R10 still busy", busy, 1);
      end
      while (done_cnt == start_cnt) @(negedge clk);
      e0 = err_code; d0 = rd_data;
      repeat (4) @(negedge clk);
      chk(err_code == e0 && rd_data == d0, "R11 result hold", {err_code, rd_data}, {e0, d0});
      chk(!busy && !cmd_valid, "R10 idle after done", {busy, cmd_valid}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !cmd_valid, "R1 flags", {busy, done, cmd_valid}, 0);
      chk(err_code == 0 && rd_data == 0, "R1 results", {err_code, rd_data}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_txn(1'b0, 8'hA3, 8'h10, 8'h5A, 3'b000, 0, 8'h00, 1'b0); // plain write
      run_txn(1'b0, 8'h40, 8'h22, 8'h81, 3'b010, 1, 8'h00, 1'b0); // one retry, R6
      run_txn(1'b0, 8'h7E, 8'h03, 8'hFF, 3'b101, 4, 8'h00, 1'b0); // R3 exhausted, bits 0 and 2
      run_txn(1'b0, 8'h12, 8'h99, 8'h00, 3'b111, 2, 8'h00, 1'b0); // succeeds on third attempt
      run_txn(1'b0, 8'h12, 8'h44, 8'h00, 3'b010, 9, 8'h00, 1'b0); // R3 bit 1 only
      run_txn(1'b1, 8'hA1, 8'h07, 8'h00, 3'b000, 0, 8'hC6, 1'b0); // plain read
      run_txn(1'b1, 8'h30, 8'h0F, 8'h00, 3'b100, 4, 8'h5D, 1'b0); // R5 exhausted read
      run_txn(1'b1, 8'hEE, 8'hF0, 8'h00, 3'b001, 3, 8'h90, 1'b0); // R6 last allowed attempt
      run_txn(1'b0, 8'h66, 8'h31, 8'h2B, 3'b000, 0, 8'h00, 1'b1); // R10 write with poke
      run_txn(1'b1, 8'h66, 8'h31, 8'h00, 3'b000, 0, 8'hA7, 1'b1); // R10 read with poke
      chk(q.size() == 0, "R9 every request completed", q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%0d exp=<20000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule